// File: doc/BRIEF.md
# System Options and Reset Control Register Block

This block is a small register file for the system-control corner of a microcontroller-style core. It keeps a byte of system options (watchdog enable and timeout select, stop-mode enable, debug pin enable) that software may set exactly once after each reset. After that first write the byte is frozen, so that stray code cannot alter these settings later. A second register can only be reached from the debug port. Setting its low bit asks for a full system reset, and reads of it from the user bus always give zero.

The block also gates a supply-low input with enable bits from a low-voltage control register, and can turn it into a reset request. Any reset request, whether from the debug port or from a low-voltage trip, is held for a fixed minimum number of clocks. While it is held, the block returns its own option and control registers to their reset values. A cause flag records whether the last reset came from power-on or a low-voltage trip (1) or from somewhere else (0).

The user bus reads one cycle late: `bus_rdata` shows the register at the address that was present at the previous clock edge. Register map: address 0 is the option byte, address 1 is the force-reset register, address 2 is the low-voltage control register, and address 3 reads zero.

Top module: `sysopt_regs`

## Requirements
- R1: After `rst` the option byte is 0xD3, `rst_req_o` is 0, and the low-voltage control register holds detect enable (bit 0) = 1, reset enable (bit 1) = 1 and stop enable (bit 2) = 0.
- R2: The first user write to address 0 after any reset is stored, and shows on `opt_o` and on reads of address 0.
- R3: Every later user write to address 0 is ignored until the next reset, whether `rst` or an internal reset request.
- R4: Bits 3 and 2 of the option byte always read 0, whatever value is written.
- R5: A user write to address 1 raises no reset request and changes nothing.
- R6: A read of address 1 returns 0x00, including after debug writes.
- R7: A debug write (`dbg_we`) with bit 0 = 1 raises `rst_req_o` from the next cycle for exactly 4 cycles. A debug write with bit 0 = 0 raises nothing.
- R8: During a reset request the option byte and the low-voltage control register return to their reset values, and the write-once lock reopens.
- R9: With detect enable and reset enable both set, a high `lv_i` raises `rst_req_o` on the next cycle. With either enable clear, `lv_i` has no effect.
- R10: While `stop_i` is high, `lv_i` raises a request only if stop enable is set.
- R11: Bit 7 of address 2 is the cause flag. After `rst` it equals `por_i`. After a low-voltage request it is 1. After a debug request it is 0.
- R12: When `bus_we` and `dbg_we` are high in the same cycle, the debug write is taken and the user write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| por_i | input | 1 | High while `rst` comes from power-on |
| bus_addr | input | 2 | User bus register address |
| bus_we | input | 1 | User bus write strobe |
| bus_wdata | input | 8 | User bus write data |
| bus_rdata | output | 8 | Registered read data |
| dbg_we | input | 1 | Debug-port write strobe to the force-reset register |
| dbg_wdata | input | 8 | Debug-port write data |
| lv_i | input | 1 | Supply-low level from the voltage sensor |
| stop_i | input | 1 | Core is in stop mode |
| opt_o | output | 8 | Option byte outputs |
| rst_req_o | output | 1 | System reset request |

## Verification
The write-once path is driven with a first write that has bits 3:2 set, followed by a different value and then all-ones. This separates a real lock from mere masking. A debug force and a later write show whether the lock reopens. The force-reset register gets a user write with bit 0 set and a debug write with bit 0 clear; the first separates bus from debug access, and the second separates the acceptance rule from the reset trigger. The collision case uses the second of these together with a user write to the option byte. The low-voltage input is tried with the reset enable cleared, in stop mode with and without stop enable, and with everything enabled. Three kinds of reset (power-on, plain, debug) are then told apart by the cause flag.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_OPT  = 2'd0,
    A_FRC  = 2'd1,
    A_LVC  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  localparam int unsigned FRC_BIT   = 0;
  localparam int unsigned CAUSE_BIT = 7;

  typedef struct packed {
    logic stop_en;
    logic rst_en;
    logic det_en;
  } lvd_ctl_t;

  localparam int unsigned LVC_W = $bits(lvd_ctl_t);
endpackage

// File: rtl/sysopt_wonce_reg.sv
module sysopt_wonce_reg #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] WMASK   = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= RST_VAL & WMASK;
      locked <= 1'b0;
    end else if (we && !locked) begin
      q      <= wdata & WMASK;
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/sysopt_lvd_ctl.sv
module sysopt_lvd_ctl
  import sysopt_pkg::*;
#(
  parameter lvd_ctl_t RST_CTL = '{stop_en: 1'b0, rst_en: 1'b1, det_en: 1'b1}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [LVC_W-1:0] wdata,
  input  logic             lv_i,
  input  logic             stop_i,
  output lvd_ctl_t         ctl_q,
  output logic             trip_o
);
  logic sense_on;

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= RST_CTL;
    else if (we) ctl_q <= lvd_ctl_t'(wdata);
  end

  always_comb begin
    sense_on = ctl_q.det_en && (!stop_i || ctl_q.stop_en);
    trip_o   = sense_on && ctl_q.rst_en && lv_i;
  end
endmodule

// File: rtl/sysopt_rst_req.sv
module sysopt_rst_req #(
  parameter int unsigned STRETCH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic por_i,
  input  logic dbg_fire,
  input  logic lvd_fire,
  output logic req_o,
  output logic cause_o
);
  localparam int unsigned CW = (STRETCH > 1) ? $clog2(STRETCH) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(STRETCH - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o   <= 1'b0;
      cnt     <= '0;
      cause_o <= por_i;
    end else if (dbg_fire || lvd_fire) begin
      req_o   <= 1'b1;
      cnt     <= CNT_TOP;
      cause_o <= lvd_fire;
    end else if (req_o) begin
      if (cnt == '0) req_o <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sysopt_regs.sv
module sysopt_regs
  import sysopt_pkg::*;
#(
  parameter logic [DW-1:0] OPT_RST  = 8'hD3,
  parameter logic [DW-1:0] OPT_MASK = 8'hF3,
  parameter int unsigned   STRETCH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              dbg_we,
  input  logic [DW-1:0]     dbg_wdata,
  input  logic              lv_i,
  input  logic              stop_i,
  output logic [DW-1:0]     opt_o,
  output logic              rst_req_o
);
  logic     local_rst;
  logic     user_we;
  logic     opt_we;
  logic     lvc_we;
  logic     dbg_fire;
  logic     lvd_trip;
  logic     cause;
  lvd_ctl_t lvd_ctl_q;
  logic [DW-1:0] rd_next;

  always_comb begin
    local_rst = rst || rst_req_o;
    user_we   = bus_we && !dbg_we;
    opt_we    = user_we && (reg_addr_e'(bus_addr) == A_OPT);
    lvc_we    = user_we && (reg_addr_e'(bus_addr) == A_LVC);
    dbg_fire  = dbg_we && dbg_wdata[FRC_BIT];
  end

  sysopt_wonce_reg #(
    .W       (DW),
    .RST_VAL (OPT_RST),
    .WMASK   (OPT_MASK)
  ) u_opt (
    .clk   (clk),
    .rst   (local_rst),
    .we    (opt_we),
    .wdata (bus_wdata),
    .q     (opt_o)
  );

  sysopt_lvd_ctl u_lvd (
    .clk    (clk),
    .rst    (local_rst),
    .we     (lvc_we),
    .wdata  (bus_wdata[LVC_W-1:0]),
    .lv_i   (lv_i),
    .stop_i (stop_i),
    .ctl_q  (lvd_ctl_q),
    .trip_o (lvd_trip)
  );

  sysopt_rst_req #(
    .STRETCH (STRETCH)
  ) u_req (
    .clk      (clk),
    .rst      (rst),
    .por_i    (por_i),
    .dbg_fire (dbg_fire),
    .lvd_fire (lvd_trip),
    .req_o    (rst_req_o),
    .cause_o  (cause)
  );

  always_comb begin
    rd_next = '0;
    unique case (reg_addr_e'(bus_addr))
      A_OPT: rd_next = opt_o;
      A_LVC: begin
        rd_next[LVC_W-1:0] = lvd_ctl_q;
        rd_next[CAUSE_BIT] = cause;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else bus_rdata <= rd_next;
  end
endmodule

// File: rtl/sysopt_regs_chk.sv
module sysopt_regs_chk
  import sysopt_pkg::*;
#(
  parameter int unsigned STRETCH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DW-1:0]     bus_rdata,
  input logic              dbg_we,
  input logic [DW-1:0]     dbg_wdata,
  input logic              lv_i,
  input logic              stop_i,
  input logic [DW-1:0]     opt_o,
  input logic              rst_req_o,
  input lvd_ctl_t          ctl
);
  logic        seen_wr;
  int unsigned hi_cnt;
  logic        lvd_cond;

  assign lvd_cond = ctl.det_en && ctl.rst_en && lv_i && (!stop_i || ctl.stop_en);

  always_ff @(posedge clk) begin
    if (rst || rst_req_o) seen_wr <= 1'b0;
    else if (bus_we && !dbg_we && bus_addr == A_OPT) seen_wr <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !rst_req_o) hi_cnt <= 0;
    else hi_cnt <= hi_cnt + 1;
  end

  // R4
  p_opt_gap_zero_r4: assert property (@(posedge clk) disable iff (rst)
    opt_o[3:2] == 2'b00);

  // R6
  p_frc_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
    bus_addr == A_FRC |=> bus_rdata == '0);

  // R3
  p_opt_locked_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(seen_wr) && !rst_req_o && !$past(rst_req_o)) |-> $stable(opt_o));

  // R7
  p_dbg_fires_r7: assert property (@(posedge clk) disable iff (rst)
    (dbg_we && dbg_wdata[FRC_BIT]) |=> rst_req_o);

  // R7: minimum width counted in the checker
  p_req_width_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_req_o) |-> hi_cnt >= STRETCH);

  // R9
  p_lvd_fires_r9: assert property (@(posedge clk) disable iff (rst)
    lvd_cond |=> rst_req_o);

  // R5
  p_req_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_o) |-> $past((dbg_we && dbg_wdata[FRC_BIT]) || lvd_cond));
endmodule

bind sysopt_regs sysopt_regs_chk #(.STRETCH(STRETCH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .dbg_we    (dbg_we),
  .dbg_wdata (dbg_wdata),
  .lv_i      (lv_i),
  .stop_i    (stop_i),
  .opt_o     (opt_o),
  .rst_req_o (rst_req_o),
  .ctl       (lvd_ctl_q)
);

// File: tb/test_sysopt_regs.sv
`timescale 1ns/1ps
module test_sysopt_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       por_i = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       dbg_we = 1'b0;
  logic [7:0] dbg_wdata = '0;
  logic       lv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [7:0] opt_o;
  logic       rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sysopt_regs i_sysopt_regs (
    .clk(clk), .rst(rst), .por_i(por_i),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
    .lv_i(lv_i), .stop_i(stop_i),
    .opt_o(opt_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic por);
    @(negedge clk);
    rst = 1'b1; por_i = por;
    repeat (3) @(negedge clk);
    rst = 1'b0; por_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic idle_req(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({7'd0, rst_req_o}, 8'h00, tag);
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    do_reset(1'b1);
    chk(opt_o, 8'hD3, "R1 opt_o reset");
    chk({7'd0, rst_req_o}, 8'h00, "R1 rst_req reset");
    rd(2'd0, v); chk(v, 8'hD3, "R1 read opt");
    rd(2'd2, v); chk(v, 8'h83, "R1/R11 lvc after power-on");
  endtask

  task automatic t_frc_user;
    logic [7:0] v;
    wr(2'd1, 8'hFF);
    idle_req(5, "R5 user write to force reg");
    chk(opt_o, 8'hD3, "R5 opt untouched");
    rd(2'd1, v); chk(v, 8'h00, "R6 force reg read");
  endtask

  task automatic t_collision;
    @(negedge clk);
    bus_addr = 2'd0; bus_we = 1'b1; bus_wdata = 8'h00;
    dbg_we = 1'b1; dbg_wdata = 8'h00;
    @(negedge clk);
    bus_we = 1'b0; dbg_we = 1'b0;
    chk(opt_o, 8'hD3, "R12 user write dropped");
    idle_req(5, "R7/R12 debug bit0=0 no request");
  endtask

  task automatic t_write_once;
    logic [7:0] v;
    wr(2'd0, 8'h5C);
    chk(opt_o, 8'h50, "R2 first write taken");
    chk({6'd0, opt_o[3:2]}, 8'h00, "R4 gap bits zero");
    wr(2'd0, 8'hA1);
    chk(opt_o, 8'h50, "R3 second write ignored");
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk(v, 8'h50, "R3 third write ignored");
  endtask

  task automatic t_dbg_force;
    logic [7:0] v;
    wr(2'd2, 8'h05);
    @(negedge clk);
    dbg_we = 1'b1; dbg_wdata = 8'h01;
    @(negedge clk);
    dbg_we = 1'b0; dbg_wdata = 8'h00;
    chk({7'd0, rst_req_o}, 8'h01, "R7 request cycle 1");
    for (int i = 2; i <= 4; i++) begin
      @(negedge clk);
      chk({7'd0, rst_req_o}, 8'h01, "R7 request held");
    end
    @(negedge clk);
    chk({7'd0, rst_req_o}, 8'h00, "R7 request released after 4");
    chk(opt_o, 8'hD3, "R8 opt back to reset");
    rd(2'd2, v); chk(v, 8'h03, "R8/R11 lvc reset, cause debug");
    rd(2'd1, v); chk(v, 8'h00, "R6 force reg after debug write");
    wr(2'd0, 8'h2C);
    chk(opt_o, 8'h20, "R8 lock reopened");
  endtask

  task automatic t_lvd;
    logic [7:0] v;
    wr(2'd2, 8'h01);
    @(negedge clk); lv_i = 1'b1;
    idle_req(3, "R9 reset enable clear");
    lv_i = 1'b0;
    stop_i = 1'b1;
    wr(2'd2, 8'h03);
    @(negedge clk); lv_i = 1'b1;
    idle_req(3, "R10 stop blocks detect");
    lv_i = 1'b0;
    wr(2'd2, 8'h07);
    @(negedge clk); lv_i = 1'b1;
    @(negedge clk); lv_i = 1'b0;
    chk({7'd0, rst_req_o}, 8'h01, "R10 stop enable lets trip");
    repeat (6) @(negedge clk);
    stop_i = 1'b0;
    chk({7'd0, rst_req_o}, 8'h00, "R9 request released");
    rd(2'd2, v); chk(v, 8'h83, "R11 cause low-voltage");
    chk(opt_o, 8'hD3, "R8 opt reset by low-voltage");
    @(negedge clk); lv_i = 1'b1;
    @(negedge clk); lv_i = 1'b0;
    chk({7'd0, rst_req_o}, 8'h01, "R9 default enables trip");
    repeat (6) @(negedge clk);
  endtask

  task automatic t_plain_reset;
    logic [7:0] v;
    do_reset(1'b0);
    rd(2'd2, v); chk(v, 8'h03, "R11 cause after plain reset");
    chk(opt_o, 8'hD3, "R1 opt after plain reset");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_frc_user();
    t_collision();
    t_write_once();
    t_dbg_force();
    t_lvd();
    t_plain_reset();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule